// File: doc/BRIEF.md
# Protected System Clock Control Register

This block holds the eight control bits that steer a chip's system clock generator. The bits choose what the clock-output pin carries, whether peripheral clocks halt during wait mode, the sub-oscillator drive level and port use, whether the main oscillator runs, the main-clock divide-by-8 setting, and whether the CPU runs from the sub clock. A second stored bit holds the main oscillator drive capacity. The analog oscillators, the PLL and the clock multiplexers sit outside the block and only consume these outputs.

Software reaches the register through a byte write port. A write lands only while an external protect-enable level is high. Hardware interlocks run on top of every write. A lock input freezes the bits that could disturb the running clock. A stop-mode entry pulse forces safe values into the register. When both the main and on-chip oscillators are off, the divider bit and the drive-capacity bit are pinned high. The write path classifies each cycle as open, locked or blocked. The force path then applies stop-mode entry, the sub-port rule and the oscillator-off pin, in that order, on top of the written value.

Top module: `clkctl_reg`

## Requirements
- R1: After the active-low asynchronous reset, `rd_data` is 8'h48 and `drive_hi` is 1.
- R2: A write (`wr_en` or `drv_wr_en`) while `prot_en` is 0 changes neither `rd_data` nor `drive_hi`.
- R3: With `prot_en`=1 and `mod_lock`=0, `wr_data` appears on `rd_data` after the next rising clock edge, except where a later rule forces a bit. The outputs decode the register at fixed positions. Bits [1:0] form `clkout_sel` (00 I/O port, 01 fC, 10 f8, 11 f32). Bit 2 drives `wait_periph_stop`, bit 3 `sub_drive`, bit 4 `sub_port_en`, bit 5 `main_stop`, bit 6 `div8` and bit 7 `sys_sub_sel` (1 selects the sub clock).
- R4: While `mod_lock` is 1, a protected write leaves bits 7, 5 and 2 at their previous values and updates the other bits.
- R5: Whenever bit 4 is 0, bit 3 reads 1.
- R6: A cycle with `stop_entry`=1 sets bit 3 to 1 after the edge, even over a same-cycle write.
- R7: A `stop_entry` cycle with `run_mode` of 0 (high speed), 1 (middle speed), 4 (on-chip oscillator) or 5 (on-chip low power) sets bit 6 to 1. With `run_mode` 2 (low speed) or 3 (low power), bit 6 is not forced.
- R8: In a cycle where `osc_on` is 0 and the register value after the write and stop rules has bit 5 at 1, bit 6 and `drive_hi` are 1 after the edge, over any write.
- R9: With `prot_en`=1, `drv_wr_en` loads `drv_wr_data` into `drive_hi` after the next edge, unless R8 holds it at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| prot_en | input | 1 | Write-protect release; writes land only while 1 |
| mod_lock | input | 1 | Clock-modification lock; freezes bits 7, 5, 2 |
| stop_entry | input | 1 | Single-cycle stop-mode entry pulse |
| run_mode | input | 3 | Power mode being left on stop entry |
| osc_on | input | 1 | On-chip oscillator enabled |
| drv_wr_en | input | 1 | Drive-capacity bit write strobe |
| drv_wr_data | input | 1 | Drive-capacity bit write data |
| rd_data | output | 8 | Current register value including forced bits |
| clkout_sel | output | 2 | Clock-output pin select |
| wait_periph_stop | output | 1 | Gate peripheral clocks in wait mode |
| sub_drive | output | 1 | Sub-oscillator drive strength high |
| sub_port_en | output | 1 | Sub-oscillator pins used as oscillator |
| main_stop | output | 1 | Main oscillator stopped |
| div8 | output | 1 | Main clock divide-by-8 |
| sys_sub_sel | output | 1 | System clock from sub clock |
| drive_hi | output | 1 | Main oscillator drive capacity high |

## Verification
The bench builds the block with its default parameters: reset value 8'h48, drive-bit reset 1 and lock mask 8'hA4. These defaults put every interlock in play. The locked write, the sub-port rule and the oscillator-off pin each land on a bit that a same-cycle write also targets, so the priority of forcing over writing shows up directly on `rd_data`. Stop entry is driven from fast and slow modes, and together with the write directed sequences these cover each row of the priority chain.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

    localparam int unsigned REG_W = 8;

    localparam int unsigned B_WAITSTOP = 2;
    localparam int unsigned B_SUBDRV   = 3;
    localparam int unsigned B_SUBPORT  = 4;
    localparam int unsigned B_MAINSTOP = 5;
    localparam int unsigned B_DIV8     = 6;
    localparam int unsigned B_SYSSUB   = 7;

    typedef enum logic [2:0] {
        RM_HIGH   = 3'd0,
        RM_MIDDLE = 3'd1,
        RM_LOW    = 3'd2,
        RM_LOWPWR = 3'd3,
        RM_OCO    = 3'd4,
        RM_OCOLP  = 3'd5,
        RM_RSV6   = 3'd6,
        RM_RSV7   = 3'd7
    } run_mode_e;

    typedef enum logic [1:0] {
        WS_BLOCKED = 2'd0,
        WS_OPEN    = 2'd1,
        WS_LOCKED  = 2'd2
    } wr_state_e;

    function automatic logic mode_sets_div8(run_mode_e m);
        logic r;
        unique case (m)
            RM_HIGH, RM_MIDDLE, RM_OCO, RM_OCOLP: r = 1'b1;
            default:                              r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/clkctl_wr_gate.sv
module clkctl_wr_gate
    import clkctl_pkg::*;
#(
    parameter logic [REG_W-1:0] LOCK_MASK = 8'hA4
) (
    input  logic [REG_W-1:0] cur_val,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             prot_en,
    input  logic             mod_lock,
    output logic [REG_W-1:0] merged
);

    wr_state_e         ws;
    logic [REG_W-1:0]  locked_val;

    always_comb begin
        if (!(wr_en && prot_en))
            ws = WS_BLOCKED;
        else if (mod_lock)
            ws = WS_LOCKED;
        else
            ws = WS_OPEN;
    end

    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (LOCK_MASK[i]) begin : g_frozen
            assign locked_val[i] = cur_val[i];
        end else begin : g_free
            assign locked_val[i] = wr_data[i];
        end
    end

    always_comb begin
        unique case (ws)
            WS_OPEN:   merged = wr_data;
            WS_LOCKED: merged = locked_val;
            default:   merged = cur_val;
        endcase
    end

endmodule

// File: rtl/clkctl_force.sv
module clkctl_force
    import clkctl_pkg::*;
(
    input  logic [REG_W-1:0] merged,
    input  logic             stop_entry,
    input  logic [2:0]       run_mode,
    input  logic             osc_on,
    input  logic             cur_drv,
    input  logic             drv_wr_en,
    input  logic             drv_wr_data,
    input  logic             prot_en,
    output logic [REG_W-1:0] next_val,
    output logic             next_drv
);

    logic [REG_W-1:0] after_stop;
    logic             pinned;

    always_comb begin
        after_stop = merged;
        if (stop_entry) begin
            after_stop[B_SUBDRV] = 1'b1;
            if (mode_sets_div8(run_mode_e'(run_mode)))
                after_stop[B_DIV8] = 1'b1;
        end
        if (!after_stop[B_SUBPORT])
            after_stop[B_SUBDRV] = 1'b1;
    end

    assign pinned = !osc_on && after_stop[B_MAINSTOP];

    always_comb begin
        next_val = after_stop;
        next_drv = (drv_wr_en && prot_en) ? drv_wr_data : cur_drv;
        if (pinned) begin
            next_val[B_DIV8] = 1'b1;
            next_drv         = 1'b1;
        end
    end

endmodule

// File: rtl/clkctl_reg.sv
module clkctl_reg
    import clkctl_pkg::*;
#(
    parameter logic [7:0] RESET_VAL = 8'h48,
    parameter logic       DRV_RESET = 1'b1,
    parameter logic [7:0] LOCK_MASK = 8'hA4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       prot_en,
    input  logic       mod_lock,
    input  logic       stop_entry,
    input  logic [2:0] run_mode,
    input  logic       osc_on,
    input  logic       drv_wr_en,
    input  logic       drv_wr_data,
    output logic [7:0] rd_data,
    output logic [1:0] clkout_sel,
    output logic       wait_periph_stop,
    output logic       sub_drive,
    output logic       sub_port_en,
    output logic       main_stop,
    output logic       div8,
    output logic       sys_sub_sel,
    output logic       drive_hi
);

    logic [REG_W-1:0] cfg_q;
    logic [REG_W-1:0] merged;
    logic [REG_W-1:0] next_val;
    logic             drv_q;
    logic             next_drv;

    clkctl_wr_gate #(.LOCK_MASK(LOCK_MASK)) u_gate (
        .cur_val  (cfg_q),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .prot_en  (prot_en),
        .mod_lock (mod_lock),
        .merged   (merged)
    );

    clkctl_force u_force (
        .merged      (merged),
        .stop_entry  (stop_entry),
        .run_mode    (run_mode),
        .osc_on      (osc_on),
        .cur_drv     (drv_q),
        .drv_wr_en   (drv_wr_en),
        .drv_wr_data (drv_wr_data),
        .prot_en     (prot_en),
        .next_val    (next_val),
        .next_drv    (next_drv)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= RESET_VAL;
            drv_q <= DRV_RESET;
        end else begin
            cfg_q <= next_val;
            drv_q <= next_drv;
        end
    end

    always_comb begin
        rd_data          = cfg_q;
        clkout_sel       = cfg_q[1:0];
        wait_periph_stop = cfg_q[B_WAITSTOP];
        sub_drive        = cfg_q[B_SUBDRV];
        sub_port_en      = cfg_q[B_SUBPORT];
        main_stop        = cfg_q[B_MAINSTOP];
        div8             = cfg_q[B_DIV8];
        sys_sub_sel      = cfg_q[B_SYSSUB];
        drive_hi         = drv_q;
    end

endmodule

// File: rtl/clkctl_reg_chk.sv
module clkctl_reg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       prot_en,
    input logic       mod_lock,
    input logic       stop_entry,
    input logic [2:0] run_mode,
    input logic       osc_on,
    input logic       drv_wr_en,
    input logic [7:0] rd_data,
    input logic       drive_hi
);

    AST_REG_HOLD_UNPROT: assert property (@(posedge clk) disable iff (!rst_n)
        (!prot_en && !stop_entry && (osc_on || !rd_data[5])) |=> $stable(rd_data)); // R2

    AST_DRV_HOLD_UNPROT: assert property (@(posedge clk) disable iff (!rst_n)
        (!prot_en && (osc_on || !rd_data[5])) |=> $stable(drive_hi)); // R2

    AST_LOCK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && prot_en && mod_lock) |=> $stable({rd_data[7], rd_data[5], rd_data[2]})); // R4

    AST_SUBPORT_OFF_DRV: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[4] |-> rd_data[3]); // R5

    AST_STOP_SUBDRV: assert property (@(posedge clk) disable iff (!rst_n)
        stop_entry |=> rd_data[3]); // R6

    AST_STOP_DIV8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_entry && (run_mode == 3'd0 || run_mode == 3'd1 || run_mode == 3'd4 || run_mode == 3'd5))
        |=> rd_data[6]); // R7

    AST_PIN_BOTH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_on && rd_data[5] && !(wr_en && prot_en)) |=> (rd_data[6] && drive_hi)); // R8

    AST_DRV_WRITE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_wr_en && !prot_en && (osc_on || !rd_data[5])) |=> $stable(drive_hi)); // R9

endmodule

bind clkctl_reg clkctl_reg_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .prot_en    (prot_en),
    .mod_lock   (mod_lock),
    .stop_entry (stop_entry),
    .run_mode   (run_mode),
    .osc_on     (osc_on),
    .drv_wr_en  (drv_wr_en),
    .rd_data    (rd_data),
    .drive_hi   (drive_hi)
);

// File: tb/clkctl_reg_tb.sv
`timescale 1ns/1ps
module clkctl_reg_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       prot_en = 1'b0;
    logic       mod_lock = 1'b0;
    logic       stop_entry = 1'b0;
    logic [2:0] run_mode = 3'd0;
    logic       osc_on = 1'b1;
    logic       drv_wr_en = 1'b0;
    logic       drv_wr_data = 1'b0;
    logic [7:0] rd_data;
    logic [1:0] clkout_sel;
    logic       wait_periph_stop, sub_drive, sub_port_en, main_stop, div8, sys_sub_sel, drive_hi;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int exp_reg;
    int exp_drv;

    always #2 clk = ~clk;

    clkctl_reg u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .prot_en(prot_en), .mod_lock(mod_lock), .stop_entry(stop_entry),
        .run_mode(run_mode), .osc_on(osc_on), .drv_wr_en(drv_wr_en),
        .drv_wr_data(drv_wr_data), .rd_data(rd_data), .clkout_sel(clkout_sel),
        .wait_periph_stop(wait_periph_stop), .sub_drive(sub_drive),
        .sub_port_en(sub_port_en), .main_stop(main_stop), .div8(div8),
        .sys_sub_sel(sys_sub_sel), .drive_hi(drive_hi)
    );

    function automatic int bitof(int v, int b);
        return (v >> b) & 1;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        int fld;
        check(tag, "rd_data", int'(rd_data), exp_reg);
        check(tag, "drive_hi", int'(drive_hi), exp_drv);
        fld = int'(clkout_sel) | (int'(wait_periph_stop) << 2) | (int'(sub_drive) << 3) |
              (int'(sub_port_en) << 4) | (int'(main_stop) << 5) | (int'(div8) << 6) |
              (int'(sys_sub_sel) << 7);
        check("R3", "decoded fields", fld, exp_reg);
    endtask

    // Reference: what the requirements say the register holds after one edge.
    task automatic model_edge();
        int n;
        bit fast;
        n = exp_reg;
        if (wr_en && prot_en) begin
            if (mod_lock) begin
                n = wr_data;
                if (bitof(exp_reg, 7) == 1) n = n | 128; else n = n & ~128;
                if (bitof(exp_reg, 5) == 1) n = n | 32;  else n = n & ~32;
                if (bitof(exp_reg, 2) == 1) n = n | 4;   else n = n & ~4;
            end else begin
                n = wr_data;
            end
        end
        if (drv_wr_en && prot_en) exp_drv = drv_wr_data;
        fast = (run_mode == 0) || (run_mode == 1) || (run_mode == 4) || (run_mode == 5);
        if (stop_entry) begin
            n = n | 8;
            if (fast) n = n | 64;
        end
        if (bitof(n, 4) == 0) n = n | 8;
        if (!osc_on && bitof(n, 5) == 1) begin
            n = n | 64;
            exp_drv = 1;
        end
        exp_reg = n & 255;
    endtask

    task automatic step(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all(tag);
        wr_en = 0; stop_entry = 0; drv_wr_en = 0;
    endtask

    task automatic wr(logic [7:0] d);
        wr_en = 1; wr_data = d;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #200000;
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        exp_reg = 'h48; exp_drv = 1;
        #5;
        compare_all("R1");
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        compare_all("R1");

        // R2: unprotected writes
        prot_en = 0; wr(8'hFF); drv_wr_en = 1; drv_wr_data = 0;
        step("R2");

        // R3: protected writes and clock-output codes
        prot_en = 1;
        wr(8'h13); step("R3");
        wr(8'h11); step("R3");
        wr(8'h12); step("R3");
        wr(8'h90); step("R3");

        // R5: sub port off forces drive bit
        wr(8'h00); step("R5");
        wr(8'h14); step("R5");

        // R4: lock keeps bits 7,5,2
        wr(8'hB4); step("R4");
        mod_lock = 1;
        wr(8'h4B); step("R4");
        wr(8'h13); step("R4");
        mod_lock = 0;
        wr(8'h10); step("R4");

        // R6/R7: stop entry from slow mode with same-cycle write
        run_mode = 3'd2; wr(8'h10); stop_entry = 1; step("R6");
        run_mode = 3'd3; wr(8'h30); stop_entry = 1; step("R7");
        run_mode = 3'd0; wr(8'h10); stop_entry = 1; step("R7");
        run_mode = 3'd5; wr(8'h13); stop_entry = 1; step("R7");
        run_mode = 3'd4; stop_entry = 1; step("R6");

        // R9: drive bit writes
        wr(8'h10); step("R9");
        drv_wr_en = 1; drv_wr_data = 0; step("R9");
        prot_en = 0; drv_wr_en = 1; drv_wr_data = 1; step("R9");
        prot_en = 1; drv_wr_en = 1; drv_wr_data = 1; step("R9");
        drv_wr_en = 1; drv_wr_data = 0; step("R9");

        // R8: both oscillators off pins divider and drive
        osc_on = 0; wr(8'h30); step("R8");
        wr(8'h31); drv_wr_en = 1; drv_wr_data = 0; step("R8");
        step("R8");
        osc_on = 1; wr(8'h10); drv_wr_en = 1; drv_wr_data = 0; step("R8");
        osc_on = 0; step("R8");
        wr(8'h20); step("R8");
        osc_on = 1; wr(8'h10); step("R3");

        // R2: unprotected write while oscillator-off pin inactive
        prot_en = 0; wr(8'hA5); step("R2");

        // R1: reset mid-run
        @(negedge clk); rst_n = 0; exp_reg = 'h48; exp_drv = 1;
        #1;
        compare_all("R1");
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        compare_all("R1");

        finish_run();
    end

endmodule